// File: doc/BRIEF.md
# Prescaled Multi-Mode 16-Bit Timer

This block is a 16-bit up/down counter that sits on an 8-bit register bus. An input tick strobe is divided by a selectable prescaler (1, 8, 32 or 128), and each prescaled step moves the counter according to one of four modes. The modes are: hold, free-running over the full 16-bit range, modulo up to a programmable period, and a triangle that climbs from zero to the period and falls back to zero.

Software reads the count one byte at a time. Reading the low byte also freezes the high byte in a shadow register, so a later read of the high byte is consistent with the low byte already taken. Any write to the low-byte address restarts the count from zero. A sticky overflow flag marks each return to zero. The flag drives an interrupt request, which an externally supplied mask input gates.

Top module: `tick_timer16`

## Requirements
- R1: After reset the count, the control byte, the high-byte shadow, the period and the overflow flag are all zero, so `irq_o` is low and every register reads 0x00.
- R2: Control bits 3:2 choose the prescale ratio: 00 moves the counter on every tick strobe, 01 on every 8th, 10 on every 32nd and 11 on every 128th.
- R3: With control bits 1:0 = 00 the count holds its value whatever the tick strobe does.
- R4: With mode 01 the count climbs by one per prescaled step from 0x0000 to 0xFFFF and then wraps to 0x0000; the wrap sets the overflow flag.
- R5: With mode 10 the count climbs to the period value, and the next step returns it to 0x0000 and sets the overflow flag.
- R6: With mode 11 the count climbs to the period value and then falls by one per step; reaching 0x0000 on the way down sets the overflow flag, and the next step climbs again.
- R7: In modes 10 and 11 a period of 0x0000 keeps the count at 0x0000, and the flag is set on every prescaled step.
- R8: Register map: address 0 count low, 1 count high, 2 control, 3 status, 4 period low, 5 period high. Read data appears on `bus_rdata` one cycle after the read strobe. Reading address 0 returns count bits 7:0 and, at the same edge, copies count bits 15:8 into the shadow. Reading address 1 returns the shadow, not the live high byte.
- R9: Any write to address 0 clears the count to 0x0000 regardless of the data, restarts the prescaler phase and sets the up/down direction to up.
- R10: Writes to address 1 have no effect, and control bits 7:4 always read as zero whatever is written to them.
- R11: Status bit 0 is the overflow flag. Writing 0 to it clears it, and writing 1 leaves it unchanged. A new overflow in the same cycle as a clear keeps it set.
- R12: `irq_o` is high exactly when the overflow flag is set and `mask_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Tick strobe feeding the prescaler |
| mask_i | input | 1 | Overflow interrupt enable from outside the block |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Overflow interrupt request |
| count_o | output | 16 | Current count |

## Verification
A vector table walks every mode and prescale ratio with tick counts placed just before, at and past each turning point. This separates an off-by-one period compare from a correct one, a triangle that turns at the period from one that overshoots, and ratios of 8, 32 and 128 from each other. Directed runs cover a full 65536-step wrap, a read of the high byte after the counter has moved on, to show that the shadow is returned and not the live byte, and clears issued in mid prescale and mid descent, to show that the prescaler phase and the direction both restart.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_FREE = 2'b01,
    MODE_MOD  = 2'b10,
    MODE_UPDN = 2'b11
  } tmode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PER_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_PER_HI = 3'd5;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PRE_W = 7,
  parameter int SH1   = 3,
  parameter int SH2   = 5,
  parameter int SH3   = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] div_i,
  output logic       adv_o
);
  localparam logic [PRE_W-1:0] LIM1 = PRE_W'((1 << SH1) - 1);
  localparam logic [PRE_W-1:0] LIM2 = PRE_W'((1 << SH2) - 1);
  localparam logic [PRE_W-1:0] LIM3 = PRE_W'((1 << SH3) - 1);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    case (div_i)
      2'd0:    limit = '0;
      2'd1:    limit = LIM1;
      2'd2:    limit = LIM2;
      default: limit = LIM3;
    endcase
  end

  assign adv_o = tick_i && !clr_i && (pcnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pcnt_q <= '0;
    end else if (tick_i) begin
      pcnt_q <= adv_o ? '0 : pcnt_q + 1'b1;
    end
  end

  AST_ADV_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    adv_o |-> tick_i);  // R2
  AST_CLR_PHASE: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> pcnt_q == '0);  // R9
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             adv_i,
  input  tmode_e           mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             ovf;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    ovf    = 1'b0;
    if (adv_i) begin
      case (mode_i)
        MODE_HOLD: ;
        MODE_FREE: begin
          cnt_d = cnt_q + ONE;
          ovf   = (cnt_q == '1);
        end
        MODE_MOD: begin
          if (cnt_q >= period_i) begin
            cnt_d = '0;
            ovf   = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          if (period_i == '0) begin
            cnt_d  = '0;
            down_d = 1'b0;
            ovf    = 1'b1;
          end else if (!down_q) begin
            if (cnt_q < period_i) begin
              cnt_d = cnt_q + ONE;
            end else if (cnt_q == ONE) begin
              cnt_d = '0;
              ovf   = 1'b1;
            end else begin
              cnt_d  = cnt_q - ONE;
              down_d = 1'b1;
            end
          end else if (cnt_q <= ONE) begin
            cnt_d  = '0;
            down_d = 1'b0;
            ovf    = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf && !clr_i;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0 && !down_q);  // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && mode_i == MODE_HOLD) |=> $stable(cnt_q));  // R3
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && adv_i && mode_i == MODE_FREE && cnt_q == '1) |=> cnt_q == '0);  // R4
  AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && adv_i && (mode_i == MODE_MOD || mode_i == MODE_UPDN) && period_i == '0)
      |=> cnt_q == '0);  // R7
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              mask_i,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic [2*DATA_W-1:0] count_o
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int CTRL_W = 4;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  period_q;
  logic [DATA_W-1:0] shadow_q;
  logic              flag_q;
  logic              clr;
  logic              adv;
  logic              ovf;
  logic [CNT_W-1:0]  cnt;
  tmode_e            mode;

  assign clr  = bus_wr && (bus_addr == A_CNT_LO);
  assign mode = tmode_e'(ctrl_q[1:0]);

  ptmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr),
    .tick_i(tick_i),
    .div_i (ctrl_q[3:2]),
    .adv_o (adv)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .adv_i   (adv),
    .mode_i  (mode),
    .period_i(period_q),
    .cnt_o   (cnt),
    .ovf_o   (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL:   ctrl_q                     <= bus_wdata[CTRL_W-1:0];
          A_PER_LO: period_q[DATA_W-1:0]       <= bus_wdata;
          A_PER_HI: period_q[CNT_W-1:DATA_W]   <= bus_wdata;
          default: ;
        endcase
      end
      if (ovf) begin
        flag_q <= 1'b1;
      end else if (bus_wr && bus_addr == A_STAT && !bus_wdata[0]) begin
        flag_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      shadow_q  <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CNT_LO: begin
          bus_rdata <= cnt[DATA_W-1:0];
          shadow_q  <= cnt[CNT_W-1:DATA_W];
        end
        A_CNT_HI: bus_rdata <= shadow_q;
        A_CTRL:   bus_rdata <= DATA_W'(ctrl_q);
        A_STAT:   bus_rdata <= DATA_W'(flag_q);
        A_PER_LO: bus_rdata <= period_q[DATA_W-1:0];
        A_PER_HI: bus_rdata <= period_q[CNT_W-1:DATA_W];
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq_o   = flag_q && mask_i;
  assign count_o = cnt;

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag_q);  // R11
  AST_SHADOW_LATCH: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CNT_LO) |=> shadow_q == $past(cnt[CNT_W-1:DATA_W]));  // R8
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTRL) |=> bus_rdata[DATA_W-1:CTRL_W] == '0);  // R10
  AST_HI_READ_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CNT_HI) |=> bus_rdata == $past(shadow_q));  // R8
endmodule

// File: tb/test_tick_timer16.sv
`timescale 1ns/1ps
module test_tick_timer16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        mask = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [15:0] count;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tick_timer16 i_tick_timer16 (
    .clk(clk), .rst(rst), .tick_i(tick), .mask_i(mask),
    .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq), .count_o(count)
  );

  typedef struct packed {
    logic [1:0]  div;
    logic [1:0]  mode;
    logic [15:0] per;
    logic [15:0] nt;
    logic [15:0] ecnt;
    logic        eflag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 16'd0, 16'd5,   16'd5, 1'b0},  // R4 free run
    '{2'd1, 2'd1, 16'd0, 16'd20,  16'd2, 1'b0},  // R2 /8
    '{2'd2, 2'd1, 16'd0, 16'd100, 16'd3, 1'b0},  // R2 /32
    '{2'd3, 2'd1, 16'd0, 16'd300, 16'd2, 1'b0},  // R2 /128
    '{2'd0, 2'd2, 16'd4, 16'd4,   16'd4, 1'b0},  // R5 at period
    '{2'd0, 2'd2, 16'd4, 16'd5,   16'd0, 1'b1},  // R5 return
    '{2'd0, 2'd2, 16'd4, 16'd7,   16'd2, 1'b1},  // R5 next lap
    '{2'd0, 2'd3, 16'd3, 16'd4,   16'd2, 1'b0},  // R6 descending
    '{2'd0, 2'd3, 16'd3, 16'd6,   16'd0, 1'b1},  // R6 bottom
    '{2'd0, 2'd3, 16'd3, 16'd8,   16'd2, 1'b1},  // R6 climbing again
    '{2'd0, 2'd2, 16'd0, 16'd3,   16'd0, 1'b1},  // R7 modulo zero
    '{2'd0, 2'd3, 16'd0, 16'd2,   16'd0, 1'b1},  // R7 triangle zero
    '{2'd0, 2'd0, 16'd9, 16'd10,  16'd0, 1'b0}   // R3 hold
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic run_fast(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(4ns * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk("R1 count", count, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    bus_read(3'd2, v); chk("R1 control", 16'(v), 16'h0);
    bus_read(3'd3, v); chk("R1 status", 16'(v), 16'h0);
    bus_read(3'd1, v); chk("R1 shadow", 16'(v), 16'h0);
    bus_read(3'd4, v); chk("R1 period", 16'(v), 16'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      bus_write(3'd2, 8'h00);
      bus_write(3'd4, VECS[i].per[7:0]);
      bus_write(3'd5, VECS[i].per[15:8]);
      bus_write(3'd3, 8'h00);
      bus_write(3'd2, {4'h0, VECS[i].div, VECS[i].mode});
      bus_write(3'd0, 8'h00);
      pulse_ticks(int'(VECS[i].nt));
      chk($sformatf("vector %0d R2-R7 count", i), count, VECS[i].ecnt);
      bus_read(3'd3, v);
      chk($sformatf("vector %0d R11 flag", i), 16'(v[0]), 16'(VECS[i].eflag));
    end

    // R4 full wrap with continuous ticks
    bus_write(3'd2, 8'h01);
    bus_write(3'd3, 8'h00);
    bus_write(3'd0, 8'h00);
    run_fast(65535);
    chk("R4 top", count, 16'hFFFF);
    bus_read(3'd3, v); chk("R4 no flag before wrap", 16'(v[0]), 16'h0);
    run_fast(1);
    chk("R4 wrapped", count, 16'h0);
    bus_read(3'd3, v); chk("R4 flag on wrap", 16'(v[0]), 16'h1);

    // R12 interrupt gating, R11 write semantics
    mask = 1'b0; @(negedge clk);
    chk("R12 masked", 16'(irq), 16'h0);
    mask = 1'b1; @(negedge clk);
    chk("R12 unmasked", 16'(irq), 16'h1);
    bus_write(3'd3, 8'h01);
    bus_read(3'd3, v); chk("R11 write one keeps flag", 16'(v[0]), 16'h1);
    bus_write(3'd3, 8'hFE);
    bus_read(3'd3, v); chk("R11 write zero clears", 16'(v[0]), 16'h0);
    chk("R12 flag low", 16'(irq), 16'h0);
    mask = 1'b0;

    // R8 shadow latch
    bus_write(3'd0, 8'h00);
    run_fast(300);
    bus_write(3'd2, 8'h00);
    bus_read(3'd0, v); chk("R8 low byte", 16'(v), 16'h2C);
    bus_write(3'd2, 8'h01);
    run_fast(300);
    bus_write(3'd2, 8'h00);
    chk("R8 live count", count, 16'h0258);
    bus_read(3'd1, v); chk("R8 high reads shadow", 16'(v), 16'h01);
    bus_read(3'd0, v); chk("R8 low byte again", 16'(v), 16'h58);
    bus_read(3'd1, v); chk("R8 high after relatch", 16'(v), 16'h02);

    // R10 read-only high, reserved control bits
    bus_write(3'd1, 8'h77);
    bus_read(3'd1, v); chk("R10 high write ignored", 16'(v), 16'h02);
    chk("R10 count untouched", count, 16'h0258);
    bus_write(3'd2, 8'hF0);
    bus_read(3'd2, v); chk("R10 reserved bits zero", 16'(v), 16'h00);

    // R9 clear with arbitrary data
    bus_write(3'd0, 8'hA5);
    chk("R9 clear", count, 16'h0);

    // R9 prescaler phase restarts
    bus_write(3'd2, 8'h05);
    bus_write(3'd0, 8'h00);
    pulse_ticks(5);
    bus_write(3'd0, 8'h00);
    pulse_ticks(7);
    chk("R9 prescaler restarted", count, 16'h0);
    pulse_ticks(1);
    chk("R9 first step after eight", count, 16'h1);

    // R9 direction back to up
    bus_write(3'd4, 8'h03);
    bus_write(3'd5, 8'h00);
    bus_write(3'd2, 8'h03);
    bus_write(3'd0, 8'h00);
    pulse_ticks(4);
    chk("R9 descending before clear", count, 16'h2);
    bus_write(3'd3, 8'h00);
    bus_write(3'd0, 8'h00);
    pulse_ticks(1);
    chk("R9 climbs after clear", count, 16'h1);
    bus_read(3'd3, v); chk("R9 no flag after clear", 16'(v[0]), 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule